// File: doc/BRIEF.md
# Two-Channel Split-Count Pulse Generator

This block drives two pulse outputs. Each output has its own 32-bit count word that gives a high-time count and a low-time count. The output is high for the high count of divided ticks, then low for the low count of divided ticks, and the pattern repeats. A third word holds the control fields for both channels:

- an output enable,
- a two-bit choice among four free-running source tick strobes,
- a seven-bit prescale divider,
- a gate that lets the prescaler and the counter advance.

There is no polarity control. To get an inverted waveform, software swaps the two counts.

Software talks to the block through plain write and read strobes that select a 32-bit word by index. There is no streaming data path, so the interface has no valid/ready handshake and no back-pressure. A read returns the selected word combinationally in the same cycle. The source ticks are single-cycle enables in the block's own clock domain; they stand in for real clock sources.

Top module: `dual_pwm_gen`

## Requirements
- R1: After reset, all three words read as zero and both outputs are low.
- R2: Word index 0 (byte offset 0x0), index 1 (0x4) and index 2 (0x8) each read back the last value written. A write to index 3 changes nothing, and reading index 3 returns zero. A read with `bus_rd` low returns zero.
- R3: Count word layout: bits [31:16] hold the high count and bits [15:0] the low count. Control word layout for channel c (0 or 1):
  - enable at bit c,
  - source select at bits [5+2c:4+2c],
  - divider at bits [14+8c:8+8c],
  - gate at bit 15+8c.
- R4: A channel is paced only by `src_tick[sel]`, where sel is its source select field. Strobes on the other source inputs have no effect on it.
- R5: With divider value d, a channel produces one divided tick for every d+1 pulses of its selected source. With d = 0, every source pulse becomes a divided tick.
- R6: The first cycle after the write edge that sets the enable still shows a low output. From the next cycle on, the output is high for H divided ticks, then low for L divided ticks, and the pattern repeats.
- R7: With a high count of 0, the enabled output stays low for ever.
- R8: With a low count of 0 and a nonzero high count, the output still goes low for exactly one divided tick in each period.
- R9: Clearing the enable bit forces the output low in the cycle right after the write edge, without waiting for the period to end.
- R10: While a channel's gate bit is clear, its waveform does not advance, and its output holds its level.
- R11: The high and low counts are captured when the channel starts. Writing the count word while the channel runs leaves the running waveform unchanged.
- R12: The two channels run independently: each follows its own fields and count word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe; the word is updated at the clock edge |
| bus_rd | input | 1 | Read strobe; gates `bus_rdata` |
| bus_word | input | 2 | Word index: 0 = channel 0 counts, 1 = channel 1 counts, 2 = control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| src_tick | input | 4 | Four source tick strobes, one cycle wide per pulse |
| pwm_out | output | 2 | Pulse outputs, bit c for channel c |

## Verification
The risky coincidences come from register writes:
- A write to the control word can land in the same cycle as a divided tick or a phase boundary, changing the divider, gate, select or enable while the prescaler wraps or the counter turns from high to low.
- A count-word write can land while the channel is restarting.

The bench provokes these with random writes of small counts and small dividers while the four source strobes toggle at random every cycle. That makes edges coincide with ticks often. The bench judges the result by comparing both outputs in every cycle against a bench model of the requirements. Directed cases then pin down the exact R6 and R8 waveforms, the immediate disable, the gate freeze and the source select.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int CH_N   = 2;
  localparam int CNT_W  = 16;
  localparam int DIV_W  = 7;
  localparam int SRC_N  = 4;
  localparam int SEL_W  = $clog2(SRC_N);
  localparam int WORD_W = 32;
  localparam int IDX_W  = 2;
  localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(CH_N);

  // control word field positions for channel ch
  function automatic int sel_lsb(input int ch);
    return 4 + SEL_W * ch;
  endfunction
  function automatic int div_lsb(input int ch);
    return 8 + 8 * ch;
  endfunction
  function automatic int gate_bit(input int ch);
    return 15 + 8 * ch;
  endfunction

  typedef struct packed {
    logic             en;
    logic             gate;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
  } chan_cfg_t;
endpackage

// File: rtl/dpwm_regs.sv
module dpwm_regs
  import dpwm_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [IDX_W-1:0]             bus_word,
  input  logic [WORD_W-1:0]            bus_wdata,
  output logic [WORD_W-1:0]            bus_rdata,
  output chan_cfg_t [CH_N-1:0]         cfg,
  output logic [CH_N-1:0][CNT_W-1:0]   hi_cnt,
  output logic [CH_N-1:0][CNT_W-1:0]   lo_cnt
);
  logic [CH_N-1:0][WORD_W-1:0] cnt_q;
  logic [WORD_W-1:0]           ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ctrl_q <= '0;
    end else if (bus_wr) begin
      if (bus_word == CTRL_IDX) ctrl_q <= bus_wdata;
      for (int c = 0; c < CH_N; c++) begin
        if (bus_word == IDX_W'(c)) cnt_q[c] <= bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_word == CTRL_IDX) bus_rdata = ctrl_q;
      for (int c = 0; c < CH_N; c++) begin
        if (bus_word == IDX_W'(c)) bus_rdata = cnt_q[c];
      end
    end
  end

  always_comb begin
    for (int c = 0; c < CH_N; c++) begin
      cfg[c].en   = ctrl_q[c];
      cfg[c].gate = ctrl_q[gate_bit(c)];
      cfg[c].sel  = ctrl_q[sel_lsb(c) +: SEL_W];
      cfg[c].div  = ctrl_q[div_lsb(c) +: DIV_W];
      hi_cnt[c]   = cnt_q[c][WORD_W-1 -: CNT_W];
      lo_cnt[c]   = cnt_q[c][CNT_W-1:0];
    end
  end
endmodule

// File: rtl/dpwm_prescale.sv
module dpwm_prescale
  import dpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SRC_N-1:0] src,
  input  logic [SEL_W-1:0] sel,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] pcnt;
  logic             src_hit;
  logic             wrap;

  assign src_hit = src[sel];
  // >= so a divider lowered below the running count wraps at once
  assign wrap    = (pcnt >= div);
  assign tick    = run & src_hit & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pcnt <= '0;
    else if (!run)     pcnt <= '0;
    else if (src_hit)  pcnt <= wrap ? '0 : pcnt + 1'b1;
  end
endmodule

// File: rtl/dpwm_wave.sv
module dpwm_wave
  import dpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] hi_in,
  input  logic [CNT_W-1:0] lo_in,
  output logic             level
);
  logic             started;
  logic             phase_hi;
  logic [CNT_W-1:0] hi_q, lo_q, cnt;
  logic [CNT_W:0]   nxt;
  logic             hi_done, lo_done;

  assign nxt     = {1'b0, cnt} + 1'b1;
  assign hi_done = (nxt >= {1'b0, hi_q});
  assign lo_done = (nxt >= {1'b0, lo_q});   // lo of 0 still costs one tick

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started  <= 1'b0;
      phase_hi <= 1'b0;
      hi_q     <= '0;
      lo_q     <= '0;
      cnt      <= '0;
    end else if (!en) begin
      started  <= 1'b0;
      phase_hi <= 1'b0;
      cnt      <= '0;
    end else if (!started) begin
      started  <= 1'b1;
      hi_q     <= hi_in;
      lo_q     <= lo_in;
      cnt      <= '0;
      phase_hi <= (hi_in != '0);
    end else if (tick) begin
      if (phase_hi) begin
        if (hi_done) begin
          phase_hi <= 1'b0;
          cnt      <= '0;
        end else begin
          cnt <= nxt[CNT_W-1:0];
        end
      end else begin
        if (lo_done) begin
          phase_hi <= (hi_q != '0);
          cnt      <= '0;
        end else begin
          cnt <= nxt[CNT_W-1:0];
        end
      end
    end
  end

  // enable gates the output directly: disable takes effect at once
  assign level = en & started & phase_hi;
endmodule

// File: rtl/dual_pwm_gen.sv
module dual_pwm_gen
  import dpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_word,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [3:0]        src_tick,
  output logic [1:0]        pwm_out
);
  chan_cfg_t [CH_N-1:0]       cfg;
  logic [CH_N-1:0][CNT_W-1:0] hi_cnt;
  logic [CH_N-1:0][CNT_W-1:0] lo_cnt;
  logic [CH_N-1:0]            ch_tick;

  dpwm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg(cfg), .hi_cnt(hi_cnt), .lo_cnt(lo_cnt)
  );

  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    dpwm_prescale u_pre (
      .clk(clk), .rst_n(rst_n),
      .run(cfg[g].en & cfg[g].gate),
      .src(src_tick), .sel(cfg[g].sel), .div(cfg[g].div),
      .tick(ch_tick[g])
    );
    dpwm_wave u_wave (
      .clk(clk), .rst_n(rst_n), .en(cfg[g].en), .tick(ch_tick[g]),
      .hi_in(hi_cnt[g]), .lo_in(lo_cnt[g]), .level(pwm_out[g])
    );
  end
endmodule

// File: rtl/dual_pwm_gen_chk.sv
module dual_pwm_gen_chk
  import dpwm_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_wr,
  input logic [1:0]                 bus_word,
  input chan_cfg_t [CH_N-1:0]       cfg,
  input logic [CH_N-1:0][CNT_W-1:0] hi_cnt,
  input logic [CH_N-1:0][CNT_W-1:0] lo_cnt,
  input logic [1:0]                 pwm_out
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_low_R1: assert (pwm_out == 2'b00)
        else $error("outputs not low in reset");
    end
  end

  assert_idx3_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_word == 2'd3) |=> ($stable(cfg) && $stable(hi_cnt) && $stable(lo_cnt)));

  for (genvar g = 0; g < CH_N; g++) begin : g_a
    assert_off_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg[g].en |-> !pwm_out[g]);

    assert_gate_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[g].en && $past(cfg[g].en) && $past(cfg[g].en, 2) && !$past(cfg[g].gate))
        |-> $stable(pwm_out[g]));
  end
endmodule

bind dual_pwm_gen dual_pwm_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
  .cfg(cfg), .hi_cnt(hi_cnt), .lo_cnt(lo_cnt), .pwm_out(pwm_out)
);

// File: tb/dual_pwm_gen_test.sv
module dual_pwm_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_word = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  src_tick = '0;
  logic [1:0]  pwm_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0, rand_src = 0;

  always #4 clk = ~clk;   // 125 MHz

  dual_pwm_gen uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_tick(src_tick), .pwm_out(pwm_out)
  );

  // ---------------- requirement model ----------------
  logic [31:0] m_ctrl = '0;
  logic [31:0] m_cw [2] = '{0, 0};
  int m_pc [2] = '{0, 0};
  int m_cnt[2] = '{0, 0};
  int m_hi [2] = '{0, 0};
  int m_lo [2] = '{0, 0};
  bit m_st [2] = '{0, 0};
  bit m_ph [2] = '{0, 0};

  function automatic bit f_en(input logic [31:0] w, input int c);   return w[c]; endfunction
  function automatic bit f_gate(input logic [31:0] w, input int c); return w[15+8*c]; endfunction
  function automatic int f_sel(input logic [31:0] w, input int c);  return (w >> (4+2*c)) & 3; endfunction
  function automatic int f_div(input logic [31:0] w, input int c);  return (w >> (8+8*c)) & 127; endfunction
  function automatic bit exp_out(input int c); return f_en(m_ctrl, c) && m_st[c] && m_ph[c]; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = '0; m_cw[0] = '0; m_cw[1] = '0;
      for (int c = 0; c < 2; c++) begin
        m_pc[c] = 0; m_cnt[c] = 0; m_st[c] = 0; m_ph[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit en, run, s, tk;
        int dv;
        en  = f_en(m_ctrl, c);
        run = en && f_gate(m_ctrl, c);
        dv  = f_div(m_ctrl, c);
        s   = src_tick[f_sel(m_ctrl, c)];
        tk  = run && s && (m_pc[c] >= dv);
        if (!run) m_pc[c] = 0;
        else if (s) m_pc[c] = (m_pc[c] >= dv) ? 0 : m_pc[c] + 1;
        if (!en) begin
          m_st[c] = 0; m_ph[c] = 0; m_cnt[c] = 0;
        end else if (!m_st[c]) begin
          m_st[c] = 1; m_hi[c] = int'(m_cw[c][31:16]); m_lo[c] = int'(m_cw[c][15:0]);
          m_cnt[c] = 0; m_ph[c] = (m_hi[c] != 0);
        end else if (tk) begin
          if (m_ph[c]) begin
            if (m_cnt[c] + 1 >= m_hi[c]) begin m_ph[c] = 0; m_cnt[c] = 0; end
            else m_cnt[c]++;
          end else begin
            if (m_cnt[c] + 1 >= m_lo[c]) begin m_cnt[c] = 0; m_ph[c] = (m_hi[c] != 0); end
            else m_cnt[c]++;
          end
        end
      end
      if (bus_wr) begin
        if (bus_word == 2'd2) m_ctrl = bus_wdata;
        else if (bus_word < 2'd2) m_cw[bus_word[0]] = bus_wdata;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle model comparison: R4 R5 R6 R7 R8 R9 R10 R11 R12
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < 2; c++)
        check(pwm_out[c] == exp_out(c), $sformatf("R6 model ch%0d", c), pwm_out[c], exp_out(c));
    end
  end

  always @(negedge clk) if (rand_src) src_tick <= 4'($urandom);

  task automatic wr_word(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_word = idx; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_check(input logic [1:0] idx, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_rd = 1; bus_word = idx; #1;
    check(bus_rdata == exp, tag, bus_rdata, exp);
    bus_rd = 0;
  endtask

  task automatic count_high(input int ch, input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      if (pwm_out[ch]) hits++;
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] cw(input int hi, input int lo);
    return {16'(hi), 16'(lo)};
  endfunction

  localparam logic [31:0] A_ON = 32'h0000_8001;   // ch0 enable + gate, sel 0, div 0

  initial begin
    int h;
    void'($urandom(32'h5EED_0042));
    wait_cyc(3);
    #1 check(pwm_out == 2'b00, "R1 outputs in reset", pwm_out, 0);
    @(negedge clk); rst_n = 1;
    rd_check(0, 0, "R1 word0"); rd_check(1, 0, "R1 word1"); rd_check(2, 0, "R1 ctrl");

    // R2 readback with channels kept off (enable bits 0,1 cleared)
    wr_word(0, 32'hDEAD_BEEF); wr_word(1, 32'h1234_5678); wr_word(2, 32'hA5A5_5A5C);
    rd_check(0, 32'hDEAD_BEEF, "R2 word0"); rd_check(1, 32'h1234_5678, "R2 word1");
    rd_check(2, 32'hA5A5_5A5C, "R2 ctrl");
    wr_word(3, 32'hFFFF_FFFF);
    rd_check(3, 0, "R2 idx3 read"); rd_check(2, 32'hA5A5_5A5C, "R2 ctrl after idx3");
    rd_check(0, 32'hDEAD_BEEF, "R2 word0 after idx3");
    @(negedge clk); bus_word = 2; #1;
    check(bus_rdata == 0, "R2 no strobe", bus_rdata, 0);

    // R6 / R3: hi=3 lo=2, src 0 every cycle, div 0
    wr_word(2, 0); src_tick = 4'b0001;
    wr_word(0, cw(3, 2)); wr_word(2, A_ON);
    #1 check(pwm_out[0] == 0, "R6 first cycle low", pwm_out[0], 0);
    for (int i = 1; i < 21; i++) begin
      bit e;
      e = ((i - 1) % 5) < 3;
      @(negedge clk); #1;
      check(pwm_out[0] == e, $sformatf("R6 pattern i=%0d", i), pwm_out[0], e);
    end

    // R7: hi=0 stays low
    wr_word(2, 0); wr_word(0, cw(0, 3)); wr_word(2, A_ON);
    count_high(0, 30, h); check(h == 0, "R7 hi zero", h, 0);

    // R8: hi=4 lo=0 -> one low tick per period
    wr_word(2, 0); wr_word(0, cw(4, 0)); wr_word(2, A_ON);
    for (int i = 1; i < 21; i++) begin
      bit e;
      e = ((i - 1) % 5) < 4;
      @(negedge clk); #1;
      check(pwm_out[0] == e, $sformatf("R8 pattern i=%0d", i), pwm_out[0], e);
    end

    // R9: disable while high
    for (int i = 0; i < 10 && !pwm_out[0]; i++) begin @(negedge clk); #1; end
    check(pwm_out[0] == 1, "R9 precondition high", pwm_out[0], 1);
    wr_word(2, 32'h0000_8000);
    #1 check(pwm_out[0] == 0, "R9 immediate low", pwm_out[0], 0);

    // R10: gate cleared freezes level
    wr_word(0, cw(3, 2)); wr_word(2, A_ON); wait_cyc(7);
    wr_word(2, 32'h0000_0001);
    begin
      bit v;
      #1 v = pwm_out[0];
      count_high(0, 20, h);
      check(h == (v ? 20 : 0), "R10 gate freeze", h, v ? 20 : 0);
    end

    // R11: count write while running is not applied
    wr_word(2, 0); wr_word(2, A_ON); wait_cyc(6);
    wr_word(0, cw(0, 9)); wait_cyc(10);
    count_high(0, 25, h); check(h == 15, "R11 latched counts", h, 15);

    // R4 R5 R12: ch1 on source 2, div 1, hi=1 lo=1; ch0 off
    wr_word(2, 0); src_tick = 4'b0100;
    wr_word(1, cw(1, 1));
    wr_word(2, 32'h0081_0082);   // ch1 en (bit1), sel 2 at [7:6], div 1 at [22:16], gate bit 23
    wait_cyc(8);
    count_high(1, 20, h); check(h == 10, "R5 divide by two", h, 10);
    #1 check(pwm_out[0] == 0, "R12 ch0 unaffected", pwm_out[0], 0);
    // R4: pulses only on other sources -> ch1 never advances, stays high
    src_tick = 4'b1011;
    wr_word(2, 0); wr_word(2, 32'h0081_0082); wait_cyc(3);
    count_high(1, 20, h); check(h == 20, "R4 other sources ignored", h, 20);

    // random phase: model compares every cycle
    rand_src = 1;
    for (int k = 0; k < 60; k++) begin
      int pick;
      pick = $urandom_range(0, 2);
      if (pick == 2) begin
        logic [31:0] w;
        w = '0;
        w[0] = 1'($urandom); w[1] = 1'($urandom);
        w[5:4] = 2'($urandom); w[7:6] = 2'($urandom);
        w[14:8] = 7'($urandom_range(0, 2)); w[22:16] = 7'($urandom_range(0, 2));
        w[15] = ($urandom_range(0, 5) != 0); w[23] = ($urandom_range(0, 5) != 0);
        wr_word(2, w);
      end else begin
        wr_word(2'(pick), cw($urandom_range(0, 4), $urandom_range(0, 4)));
      end
      wait_cyc($urandom_range(3, 60));
    end
    rand_src = 0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule